// File: doc/BRIEF.md
# Handshake Status and Interrupt Register

This block sits between a parallel host bus and a processor attached over SPI, and tracks the two-way mailbox handshake between them. A host write to the data register space raises a write-request flag. The processor drops that flag when it pulses its take strobe to collect the word. In the other direction, the processor raises a read-request flag when it posts return data, and a host read of the data buffer drops it. The host polls both flags through a status word. It can also be interrupted when return data is waiting or when its last word has been taken. Each of these two conditions has its own enable.

A small control register, written by the host, holds the two interrupt enables and a processor-enable bit. The inverse of the processor-enable bit drives the processor's reset line. The host-visible copies of the flags are re-registered, so status readback only ever changes at a bus clock rising edge. The processor strobes are assumed to be synchronous to the bus clock. Every request input is a level that the block samples at each rising edge.

Top module: `hsr_status`

## Requirements
- R1: A cycle with `hst_data_wr` high sets the write-request flag. The status word shows it on bit 22 from the second rising edge after that cycle.
- R2: A cycle with `proc_take` high and `hst_data_wr` low clears the write-request flag, and bit 22 reads 0 from the second edge on. When both are high in the same cycle, the flag is set (set wins).
- R3: A cycle with `proc_post` high sets the read-request flag. The status word shows it on bit 23 from the second rising edge after that cycle.
- R4: A cycle with `hst_data_rd` high and `proc_post` low clears the read-request flag. When both are high in the same cycle, the flag is set (set wins).
- R5: `sts_rdata` carries the read-request flag on bit 23 and the write-request flag on bit 22. Every other bit reads 0.
- R6: A cycle with `hst_ctl_wr` high loads the read-interrupt enable from `hst_wdata` bit 2, the write-interrupt enable from bit 1 and the processor enable from bit 0. `proc_reset` equals the inverse of the processor enable from the next edge.
- R7: While `rst_n` is low at a rising edge, everything is cleared: both flags, the write-accepted state, both enables and the processor enable. As a result `sts_rdata` is 0, `irq_n` is 1 and `proc_reset` is 1.
- R8: `irq_n` is low at an edge exactly when, one edge earlier, either of two conditions held: the read-request flag and the read-interrupt enable were both set, or the write-accepted state and the write-interrupt enable were both set.
- R9: The write-accepted state is set when a set write-request flag is cleared by `proc_take`. It stays set until the next cycle with `hst_data_wr` high.
- R10: A control write that clears both enables makes `irq_n` read 1 from the second edge after the write, whatever the flags are.
- R11: In a cycle with none of the flag strobes high, both flags and the write-accepted state keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low system reset |
| hst_data_wr | input | 1 | Host write to the data register space this cycle |
| hst_data_rd | input | 1 | Host read of the return data buffer this cycle |
| hst_ctl_wr | input | 1 | Host write to the control register this cycle |
| hst_wdata | input | 32 | Host write data bus |
| proc_take | input | 1 | Processor has taken the host's word |
| proc_post | input | 1 | Processor has posted new return data |
| sts_rdata | output | 32 | Status word with both flags |
| irq_n | output | 1 | Registered active-low host interrupt |
| proc_reset | output | 1 | Active-high reset to the processor |

## Verification
The assertions assume that the processor strobes are already synchronous to the bus clock. They also assume that every input is stable around each rising edge, so a strobe counts once for each edge at which it is high. The two-edge latency properties rely on reset staying high over the window; a reset inside the window cancels the check. The bench meets these assumptions by changing every input at the falling edge only. It drives reset low for several edges before any strobe. It then sweeps all combinations of the five strobes and three control bits, in several orders, against an arithmetic model of the flags.

// File: rtl/hsr_pkg.sv
// Package: shared field positions and the control register layout for the
// handshake status block. Assumes a 32-bit host data bus.
package hsr_pkg;

    // Control register contents captured from a host control write.
    typedef struct packed {
        logic rd_ie;     // interrupt when return data is waiting
        logic wr_ie;     // interrupt when host word has been taken
        logic proc_en;   // processor released from reset when set
    } hsr_ctl_t;

    localparam int unsigned HSR_CTL_W = $bits(hsr_ctl_t);

endpackage

// File: rtl/hsr_flag.sv
// Module: one handshake flag with independent set and clear requests.
// Assumes set and clear are synchronous levels; SET_WINS picks the
// winner when both arrive together.
module hsr_flag #(
    parameter bit SET_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_d;

    // Next-state selection with the configured priority.
    generate
        if (SET_WINS) begin : g_set_pri
            always_comb flag_d = set_i | (flag_o & ~clr_i);
        end else begin : g_clr_pri
            always_comb flag_d = ~clr_i & (set_i | flag_o);
        end
    endgenerate

    // Flag storage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= 1'b0;
        else        flag_o <= flag_d;
    end

endmodule

// File: rtl/hsr_mirror.sv
// Module: re-registers the flags for host readback so the host copy
// changes only on a bus clock rising edge. STAGES >= 1.
module hsr_mirror #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] host_o
);

    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // One mirror register per stage, fed from the previous one.
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= src_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign host_o = stage_q[STAGES-1];

endmodule

// File: rtl/hsr_ctl_reg.sv
// Module: host-written control register holding both interrupt enables
// and the processor enable. Field positions are parameters.
module hsr_ctl_reg
    import hsr_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned RIE_BIT = 2,
    parameter int unsigned WIE_BIT = 1,
    parameter int unsigned PEN_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output hsr_ctl_t          ctl_o
);

    hsr_ctl_t ctl_d;

    // Extract the fields from the write data.
    always_comb begin
        ctl_d.rd_ie   = wdata_i[RIE_BIT];
        ctl_d.wr_ie   = wdata_i[WIE_BIT];
        ctl_d.proc_en = wdata_i[PEN_BIT];
    end

    // Control storage, loaded on a host control write.
    always_ff @(posedge clk) begin
        if (!rst_n)    ctl_o <= '0;
        else if (wr_i) ctl_o <= ctl_d;
    end

endmodule

// File: rtl/hsr_irq.sv
// Module: combines the masked handshake conditions into a registered
// active-low interrupt. Assumes all inputs come from registers.
module hsr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic rreq_i,
    input  logic wacc_i,
    input  logic rd_ie_i,
    input  logic wr_ie_i,
    output logic irq_n_o
);

    logic cause;

    // Either enabled condition requests the interrupt.
    always_comb cause = (rreq_i & rd_ie_i) | (wacc_i & wr_ie_i);

    // Output register, so the host sees no combinational path.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n_o <= 1'b1;
        else        irq_n_o <= ~cause;
    end

endmodule

// File: rtl/hsr_status.sv
// Module: handshake status and interrupt register (top).
// Holds the write-request and read-request flags, the write-accepted
// state, the control register, the host readback mirror and the
// interrupt. Assumes processor strobes are synchronous to clk.
module hsr_status
    import hsr_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned RREQ_BIT    = 23,
    parameter int unsigned WREQ_BIT    = 22,
    parameter int unsigned RIE_BIT     = 2,
    parameter int unsigned WIE_BIT     = 1,
    parameter int unsigned PEN_BIT     = 0,
    parameter int unsigned MIRROR_STGS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_data_wr,
    input  logic              hst_data_rd,
    input  logic              hst_ctl_wr,
    input  logic [DATA_W-1:0] hst_wdata,
    input  logic              proc_take,
    input  logic              proc_post,
    output logic [DATA_W-1:0] sts_rdata,
    output logic              irq_n,
    output logic              proc_reset
);

    localparam int unsigned NFLAG = 2;
    localparam int unsigned IDX_R = 1;
    localparam int unsigned IDX_W = 0;

    logic             wreq_q;
    logic             rreq_q;
    logic             wacc_q;
    logic             wacc_set;
    logic [NFLAG-1:0] flags_src;
    logic [NFLAG-1:0] flags_host;
    hsr_ctl_t         ctl_q;

    // Host write raises the write request; processor take drops it.
    hsr_flag #(.SET_WINS(1'b1)) u_wreq (
        .clk(clk), .rst_n(rst_n),
        .set_i(hst_data_wr), .clr_i(proc_take), .flag_o(wreq_q)
    );

    // Processor post raises the read request; host read drops it.
    hsr_flag #(.SET_WINS(1'b1)) u_rreq (
        .clk(clk), .rst_n(rst_n),
        .set_i(proc_post), .clr_i(hst_data_rd), .flag_o(rreq_q)
    );

    // Write-accepted: a pending request that the processor has taken.
    always_comb wacc_set = wreq_q & proc_take & ~hst_data_wr;

    hsr_flag #(.SET_WINS(1'b0)) u_wacc (
        .clk(clk), .rst_n(rst_n),
        .set_i(wacc_set), .clr_i(hst_data_wr), .flag_o(wacc_q)
    );

    // Control register written by the host.
    hsr_ctl_reg #(
        .DATA_W(DATA_W), .RIE_BIT(RIE_BIT),
        .WIE_BIT(WIE_BIT), .PEN_BIT(PEN_BIT)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .wr_i(hst_ctl_wr), .wdata_i(hst_wdata), .ctl_o(ctl_q)
    );

    // Host-visible copy of the flags.
    always_comb begin
        flags_src        = '0;
        flags_src[IDX_R] = rreq_q;
        flags_src[IDX_W] = wreq_q;
    end

    hsr_mirror #(.W(NFLAG), .STAGES(MIRROR_STGS)) u_mirror (
        .clk(clk), .rst_n(rst_n),
        .src_i(flags_src), .host_o(flags_host)
    );

    // Place the mirrored flags in the status word.
    always_comb begin
        sts_rdata           = '0;
        sts_rdata[RREQ_BIT] = flags_host[IDX_R];
        sts_rdata[WREQ_BIT] = flags_host[IDX_W];
    end

    // Registered, maskable host interrupt.
    hsr_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .rreq_i(rreq_q), .wacc_i(wacc_q),
        .rd_ie_i(ctl_q.rd_ie), .wr_ie_i(ctl_q.wr_ie),
        .irq_n_o(irq_n)
    );

    // Processor reset is the inverse of the enable bit.
    assign proc_reset = ~ctl_q.proc_en;

endmodule

// File: rtl/hsr_status_chk.sv
// Module: property checker for hsr_status, attached with bind.
// Assumes inputs are stable around each rising edge of clk.
module hsr_status_chk #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned RREQ_BIT = 23,
    parameter int unsigned WREQ_BIT = 22,
    parameter int unsigned RIE_BIT  = 2,
    parameter int unsigned WIE_BIT  = 1,
    parameter int unsigned PEN_BIT  = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hst_data_wr,
    input logic              hst_data_rd,
    input logic              hst_ctl_wr,
    input logic [DATA_W-1:0] hst_wdata,
    input logic              proc_take,
    input logic              proc_post,
    input logic [DATA_W-1:0] sts_rdata,
    input logic              irq_n,
    input logic              proc_reset
);

    logic [DATA_W-1:0] other_mask;
    always_comb begin
        other_mask           = '1;
        other_mask[RREQ_BIT] = 1'b0;
        other_mask[WREQ_BIT] = 1'b0;
    end

    AST_WREQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hst_data_wr |-> ##2 sts_rdata[WREQ_BIT]);                    // R1
    AST_WREQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_take && !hst_data_wr) |-> ##2 !sts_rdata[WREQ_BIT]);   // R2
    AST_RREQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        proc_post |-> ##2 sts_rdata[RREQ_BIT]);                      // R3
    AST_RREQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_data_rd && !proc_post) |-> ##2 !sts_rdata[RREQ_BIT]);   // R4
    AST_STS_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rdata & other_mask) == '0);                             // R5
    AST_PROC_RST: assert property (@(posedge clk) disable iff (!rst_n)
        hst_ctl_wr |=> (proc_reset == !$past(hst_wdata[PEN_BIT])));  // R6
    AST_PROC_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_ctl_wr |=> $stable(proc_reset));                        // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_ctl_wr && !hst_wdata[RIE_BIT] && !hst_wdata[WIE_BIT])
        |-> ##2 irq_n);                                              // R10
    AST_IRQ_RREQ: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_ctl_wr && hst_wdata[RIE_BIT] && proc_post) |-> ##2 !irq_n); // R8

endmodule

bind hsr_status hsr_status_chk #(
    .DATA_W(DATA_W), .RREQ_BIT(RREQ_BIT), .WREQ_BIT(WREQ_BIT),
    .RIE_BIT(RIE_BIT), .WIE_BIT(WIE_BIT), .PEN_BIT(PEN_BIT)
) chk_i (.*);

// File: tb/hsr_status_tb_top.sv
// Bench: drives hsr_status with directed sequences and a full sweep of
// strobe and control-bit combinations, against an arithmetic model.
module hsr_status_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hst_data_wr, hst_data_rd, hst_ctl_wr;
    logic [31:0] hst_wdata;
    logic        proc_take, proc_post;
    logic [31:0] sts_rdata;
    logic        irq_n, proc_reset;

    int checks = 0;
    int errors = 0;

    // Model state
    logic m_w, m_r, m_a, m_rie, m_wie, m_pen, m_sw, m_sr, m_irq_n;

    always #2 clk = ~clk;

    hsr_status dut_i (
        .clk(clk), .rst_n(rst_n),
        .hst_data_wr(hst_data_wr), .hst_data_rd(hst_data_rd),
        .hst_ctl_wr(hst_ctl_wr), .hst_wdata(hst_wdata),
        .proc_take(proc_take), .proc_post(proc_post),
        .sts_rdata(sts_rdata), .irq_n(irq_n), .proc_reset(proc_reset)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "sts_rdata", sts_rdata,
            (32'(m_sr) << 23) | (32'(m_sw) << 22));
        chk(tag, "irq_n", {31'b0, irq_n}, {31'b0, m_irq_n});
        chk(tag, "proc_reset", {31'b0, proc_reset}, {31'b0, ~m_pen});
    endtask

    // One bus cycle: drive at falling edge, update model at rising edge,
    // sample 1 ns later.
    task automatic cyc(input logic dwr, input logic ctl, input logic drd,
                       input logic tk, input logic pst, input logic [2:0] cb,
                       input string tag);
        logic nw, nr, na, nirq;
        @(negedge clk);
        hst_data_wr = dwr; hst_ctl_wr = ctl; hst_data_rd = drd;
        proc_take = tk; proc_post = pst;
        hst_wdata = {29'h15555555, cb};
        @(posedge clk);
        nirq = ~((m_r & m_rie) | (m_a & m_wie));
        nw = dwr | (m_w & ~tk);
        nr = pst | (m_r & ~drd);
        na = ~dwr & (m_a | (m_w & tk));
        m_sw = m_w; m_sr = m_r; m_irq_n = nirq;
        m_w = nw; m_r = nr; m_a = na;
        if (ctl) begin m_rie = cb[2]; m_wie = cb[1]; m_pen = cb[0]; end
        #1;
        compare(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 3'b000, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        hst_data_wr = 0; hst_ctl_wr = 0; hst_data_rd = 0;
        proc_take = 0; proc_post = 0; hst_wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        m_w = 0; m_r = 0; m_a = 0; m_rie = 0; m_wie = 0; m_pen = 0;
        m_sw = 0; m_sr = 0; m_irq_n = 1;
        compare("R7");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        rst_n = 1'b0;
        do_reset();

        // R1: host write raises write request on bit 22
        cyc(1, 0, 0, 0, 0, 3'b000, "R1");
        idle(2, "R1");
        // R11: hold with no strobes
        idle(3, "R11");
        // R2: set wins over take in the same cycle
        cyc(1, 0, 0, 1, 0, 3'b000, "R2");
        idle(2, "R2");
        // R9 + R8: enable write-accepted interrupt, then take
        cyc(0, 1, 0, 0, 0, 3'b011, "R6");
        cyc(0, 0, 0, 1, 0, 3'b000, "R2");
        idle(3, "R9");
        // R9: next host write drops write-accepted
        cyc(1, 0, 0, 0, 0, 3'b000, "R9");
        idle(2, "R9");
        // R3 + R8: post with read enable
        cyc(0, 1, 0, 0, 0, 3'b101, "R6");
        cyc(0, 0, 0, 0, 1, 3'b000, "R3");
        idle(2, "R8");
        // R4: set wins over read, then read clears
        cyc(0, 0, 1, 0, 1, 3'b000, "R4");
        cyc(0, 0, 1, 0, 0, 3'b000, "R4");
        idle(2, "R4");
        // R10: mask all with request pending
        cyc(0, 0, 0, 0, 1, 3'b000, "R3");
        cyc(0, 1, 0, 0, 0, 3'b000, "R10");
        idle(2, "R10");
        // R6: processor enable on then off
        cyc(0, 1, 0, 0, 0, 3'b001, "R6");
        cyc(0, 1, 0, 0, 0, 3'b110, "R6");

        // R5: sweep all 256 input combinations in several orders
        for (int pass = 0; pass < 4; pass++) begin
            lfsr = 8'(pass * 37 + 1);
            for (int k = 0; k < 256; k++) begin
                logic [7:0] v;
                v = (pass == 0) ? 8'(k) : lfsr;
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                cyc(v[0], v[1], v[2], v[3], v[4], v[7:5], "R5");
            end
            idle(2, "R11");
        end

        // R7: reset in the middle of activity
        cyc(1, 1, 0, 0, 1, 3'b111, "R8");
        do_reset();
        idle(2, "R7");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule